// File: doc/BRIEF.md
# Multi-Lane Seeded Transmit Scrambler

This block scrambles the 64-bit payload of 66-bit blocks on the transmit side of a multi-lane link. Each lane runs a self-synchronous multiplicative scrambler with polynomial 1 + x^39 + x^58. All 64 payload bits of a word are processed in one clock cycle. The 2-bit sync header of each lane bypasses the scrambler and is delayed so that it stays aligned with its payload.

Each lane's 58-bit state is loaded from a seed when `load_i` is pulsed. The seed depends on the protocol mode. In fixed mode (10GBASE-R) every lane starts from a state of all ones. In offset mode lane `l` starts from the base seed plus `l`. A zero base seed is not legal in offset mode. When one is applied, the block substitutes 1 and raises a sticky error flag.

Top module: `scr_multilane`

## Requirements
- R1: For payload bit i, processed from bit 0 up to bit 63, the output bit is the input bit XOR state bit 38 XOR state bit 57. After each bit the state shifts left by one and the new output bit enters at bit 0.
- R2: A word presented with `valid_i` high is scrambled completely in that cycle. The result appears on `data_o` one cycle later, with `valid_o` high in that same cycle.
- R3: When `valid_i` and `load_i` are both low, every lane state and `data_o` hold their values.
- R4: When `load_i` is high with `mode_i` = 0 (fixed mode), every lane state becomes 0x03FFFFFFFFFFFFFF (58 ones).
- R5: When `load_i` is high with `mode_i` = 1 (offset mode), the state of lane l becomes (`seed_i` + l) mod 2^58. Lane 0 occupies the least significant slice of every flattened lane port.
- R6: When `load_i` is high in offset mode with `seed_i` = 0, the block uses 1 as the base, so lane l gets 1 + l. `cfg_err_o` then goes high on the next cycle and stays high until reset.
- R7: When `load_i` and `valid_i` are high in the same cycle, that word is scrambled starting from the newly loaded seed.
- R8: On each valid word, `hdr_o` carries the `hdr_i` of that word unchanged, one cycle later.
- R9: After reset, `valid_o` and `cfg_err_o` are 0 and every lane state is 58 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load the seed into all lane states |
| mode_i | input | 1 | 0 = fixed all-ones seed, 1 = base seed plus lane index |
| seed_i | input | 58 | Base seed for offset mode |
| valid_i | input | 1 | Payload words are valid |
| hdr_i | input | LANES*2 | Per-lane sync headers |
| data_i | input | LANES*64 | Per-lane payloads |
| valid_o | output | 1 | Scrambled words are valid |
| hdr_o | output | LANES*2 | Per-lane sync headers, delayed one cycle |
| data_o | output | LANES*64 | Per-lane scrambled payloads |
| cfg_err_o | output | 1 | Sticky flag: a zero seed was loaded in offset mode |

## Verification
Assertions check the following on every cycle:
- the state and output hold on idle cycles;
- the header passes through unchanged;
- the output valid tracks the input valid with one cycle of latency;
- lane 0 never receives a zero seed in offset mode;
- the error flag never clears once set.

Only the bench scenarios can show the rest:
- the exact scrambled bit values;
- the per-lane seed offsets, including wrap-around at 2^58;
- the fixed-mode seed;
- that the scrambler state carries correctly across idle gaps and load-plus-valid cycles.

The bench shows these by comparing every output word with a sequence-form model.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned STATE_W = 58;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned HDR_W   = 2;
  localparam int unsigned TAP_A   = 38;
  localparam int unsigned TAP_B   = 57;
  localparam logic [STATE_W-1:0] FIXED_SEED = {STATE_W{1'b1}};

  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_OFFSET = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/scr_seed_gen.sv
module scr_seed_gen
  import scr_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic                           mode_i,
  input  logic [STATE_W-1:0]             seed_i,
  output logic [LANES-1:0][STATE_W-1:0]  lane_seed_o,
  output logic                           cfg_err_o
);
  logic [STATE_W-1:0] base_eff;
  logic               seed_zero;
  logic               err_q;

  assign seed_zero = (seed_i == '0);
  assign base_eff  = seed_zero ? STATE_W'(1) : seed_i;

  for (genvar l = 0; l < LANES; l++) begin : g_seed
    assign lane_seed_o[l] = (scr_mode_e'(mode_i) == MODE_FIXED)
                          ? FIXED_SEED
                          : base_eff + STATE_W'(l);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (load_i && scr_mode_e'(mode_i) == MODE_OFFSET && seed_zero) err_q <= 1'b1;
  end

  assign cfg_err_o = err_q;

  p_seed0_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && mode_i) |-> (lane_seed_o[0] != '0));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               valid_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic [HDR_W-1:0]   hdr_i,
  input  logic [WORD_W-1:0]  data_i,
  output logic [HDR_W-1:0]   hdr_o,
  output logic [WORD_W-1:0]  data_o
);
  logic [STATE_W-1:0] state_q, state_nxt;
  logic [WORD_W-1:0]  scr_d, data_q;
  logic [HDR_W-1:0]   hdr_q;

  // serial recurrence unrolled across the word
  always_comb begin
    logic [STATE_W-1:0] st;
    logic               fb;
    st = load_i ? seed_i : state_q;
    scr_d = '0;
    for (int i = 0; i < WORD_W; i++) begin
      fb       = data_i[i] ^ st[TAP_A] ^ st[TAP_B];
      scr_d[i] = fb;
      st       = {st[STATE_W-2:0], fb};
    end
    state_nxt = st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FIXED_SEED;
      data_q  <= '0;
      hdr_q   <= '0;
    end else if (valid_i) begin
      state_q <= state_nxt;
      data_q  <= scr_d;
      hdr_q   <= hdr_i;
    end else if (load_i) begin
      state_q <= seed_i;
    end
  end

  assign data_o = data_q;
  assign hdr_o  = hdr_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !load_i) |=> ($stable(state_q) && $stable(data_o)));

  p_hdr_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (hdr_o == $past(hdr_i)));
endmodule

// File: rtl/scr_multilane.sv
module scr_multilane
  import scr_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * WORD_W,
  localparam int unsigned HW   = LANES * HDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               mode_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               valid_i,
  input  logic [HW-1:0]      hdr_i,
  input  logic [DW-1:0]      data_i,
  output logic               valid_o,
  output logic [HW-1:0]      hdr_o,
  output logic [DW-1:0]      data_o,
  output logic               cfg_err_o
);
  logic [LANES-1:0][STATE_W-1:0] lane_seed;
  logic                          valid_q;

  scr_seed_gen #(.LANES(LANES)) u_seed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .mode_i      (mode_i),
    .seed_i      (seed_i),
    .lane_seed_o (lane_seed),
    .cfg_err_o   (cfg_err_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    scr_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_i),
      .valid_i (valid_i),
      .seed_i  (lane_seed[l]),
      .hdr_i   (hdr_i[l*HDR_W +: HDR_W]),
      .data_i  (data_i[l*WORD_W +: WORD_W]),
      .hdr_o   (hdr_o[l*HDR_W +: HDR_W]),
      .data_o  (data_o[l*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: tb/scr_multilane_bench.sv
module scr_multilane_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LANES = 4;
  localparam int  SW = 58;
  localparam int  WW = 64;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  load_i = 1'b0;
  logic                  mode_i = 1'b0;
  logic [SW-1:0]         seed_i = '0;
  logic                  valid_i = 1'b0;
  logic [LANES*2-1:0]    hdr_i = '0;
  logic [LANES*WW-1:0]   data_i = '0;
  logic                  valid_o;
  logic [LANES*2-1:0]    hdr_o;
  logic [LANES*WW-1:0]   data_o;
  logic                  cfg_err_o;

  int tests = 0;
  int fails = 0;
  logic [SW-1:0]       exp_st [LANES];
  logic [LANES*WW-1:0] exp_d;
  logic                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_multilane #(.LANES(LANES)) u_scr_multilane (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .mode_i(mode_i),
    .seed_i(seed_i), .valid_i(valid_i), .hdr_i(hdr_i), .data_i(data_i),
    .valid_o(valid_o), .hdr_o(hdr_o), .data_o(data_o), .cfg_err_o(cfg_err_o)
  );

  // sequence form: y[n] = d[n] ^ y[n-39] ^ y[n-58]; y index offset by 58
  function automatic void model(input logic [SW-1:0] s, input logic [WW-1:0] d,
                                output logic [SW-1:0] ns, output logic [WW-1:0] q);
    logic [SW+WW-1:0] y;
    y = '0;
    for (int k = 0; k < SW; k++) y[SW-1-k] = s[k];
    for (int n = 0; n < WW; n++) y[SW+n] = d[n] ^ y[SW+n-39] ^ y[SW+n-58];
    for (int k = 0; k < SW; k++) ns[k] = y[SW+WW-1-k];
    q = y[SW+WW-1:SW];
  endfunction

  function automatic logic [SW-1:0] seed_of(input logic m, input logic [SW-1:0] b, input int l);
    if (!m) return {SW{1'b1}};
    return ((b == '0) ? SW'(1) : b) + SW'(l);
  endfunction

  function automatic logic [WW-1:0] pat(input int n, input int l);
    if (n == 0) return '0;
    if (n == 1) return '1;
    return {32'(n) * 32'h9E37_79B9 ^ 32'(l), 32'(l + 7) * 32'h85EB_CA6B + 32'(n)};
  endfunction

  task automatic check(input string req, input logic [LANES*WW-1:0] act,
                       input logic [LANES*WW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check results after the following posedge
  task automatic step(input logic ld, input logic vd, input logic m,
                      input logic [SW-1:0] sd, input int n, input string req);
    logic [SW-1:0] st;
    logic [WW-1:0] q;
    logic [LANES*2-1:0] h;
    load_i = ld; valid_i = vd; mode_i = m; seed_i = sd;
    for (int l = 0; l < LANES; l++) begin
      data_i[l*WW +: WW] = pat(n, l);
      hdr_i[l*2 +: 2]    = 2'((n + l) % 3 + 1);
    end
    h = hdr_i;
    for (int l = 0; l < LANES; l++) begin
      st = ld ? seed_of(m, sd, l) : exp_st[l];
      if (vd) begin
        model(st, pat(n, l), exp_st[l], q);
        exp_d[l*WW +: WW] = q;
      end else begin
        exp_st[l] = st;
      end
    end
    @(negedge clk);
    check({req, " data"}, data_o, exp_d);
    check({req, " valid"}, {{(LANES*WW-1){1'b0}}, valid_o}, {{(LANES*WW-1){1'b0}}, vd});
    if (vd) check("R8 hdr", {{(LANES*WW-LANES*2){1'b0}}, hdr_o}, {{(LANES*WW-LANES*2){1'b0}}, h});
    load_i = 1'b0; valid_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] seeds [5];
    seeds[0] = SW'(1);
    seeds[1] = {SW{1'b1}};
    seeds[2] = SW'(58'h1234_5678_9ABC_DEF);
    seeds[3] = {SW{1'b1}} - SW'(1);
    seeds[4] = SW'(58'h200_0000_0000_0000);
    exp_d = '0;
    for (int l = 0; l < LANES; l++) exp_st[l] = {SW{1'b1}};
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", {{(LANES*WW-1){1'b0}}, valid_o}, '0);
    check("R9 err", {{(LANES*WW-1){1'b0}}, cfg_err_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 state ones observed through first word without load, R1 R2
    step(0, 1, 0, '0, 2, "R9 R1");
    step(0, 1, 0, '0, 3, "R1 R2");

    // R4 fixed mode, any seed ignored
    step(1, 0, 0, seeds[2], 0, "R4 load");
    for (int n = 0; n < 6; n++) step(0, 1, 0, '0, n, "R4 R1");
    // R3 idle gaps
    for (int g = 0; g < 3; g++) step(0, 0, 0, seeds[2], 5, "R3 idle");
    step(0, 1, 0, '0, 9, "R3 resume");

    // R5 offset mode sweep including wrap
    for (int s = 0; s < 5; s++) begin
      step(1, 0, 1, seeds[s], 0, "R5 load");
      for (int n = 0; n < 5; n++) begin
        step(0, 1, 1, '0, n + s, "R5 R1");
        if (n == 2) step(0, 0, 1, '0, 4, "R3 gap");
      end
    end
    check("R6 no err", {{(LANES*WW-1){1'b0}}, cfg_err_o}, '0);

    // R7 load with valid same cycle, both modes
    step(1, 1, 1, seeds[2], 7, "R7 offset");
    step(0, 1, 1, '0, 8, "R7 next");
    step(1, 1, 0, seeds[2], 6, "R7 fixed");
    step(0, 1, 0, '0, 11, "R7 next");

    // R6 zero seed substitution and sticky error
    step(1, 0, 1, '0, 0, "R6 load");
    check("R6 err set", {{(LANES*WW-1){1'b0}}, cfg_err_o}, {{(LANES*WW-1){1'b0}}, 1'b1});
    for (int n = 0; n < 4; n++) step(0, 1, 1, '0, n + 2, "R6 R5");
    step(1, 0, 1, seeds[0], 0, "R6 reload");
    step(0, 1, 1, '0, 3, "R6 after");
    check("R6 sticky", {{(LANES*WW-1){1'b0}}, cfg_err_o}, {{(LANES*WW-1){1'b0}}, 1'b1});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule